// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counting Timer

This block is a timer peripheral that sits behind a simple word-wide register bus. One shared 16-bit prescaler divides the system clock. A parameterised number of 32-bit channels each count down by one on every prescaler tick. When a channel's counter steps below zero it has expired. On expiry it can raise a sticky pending flag and a one-clock interrupt pulse on its own line. After that it either reloads from its reload register and keeps counting, or it stops.

Software programs the unit with single-cycle writes and reads registered data one clock after it presents an address. Address bits 7:4 select a 16-byte window. Window 0 holds the unit registers and window n+1 holds channel n. Address bits 3:2 select the word inside the window, and bits 1:0 are ignored. The read port has no stall and no handshake, so there is no back-pressure. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `mct_unit`

## Requirements
- R1: After reset, every prescaler, counter, reload and control register reads 0 and all interrupt lines are low.
- R2: Window 0 word 0 is the prescaler value and word 1 is the prescaler reload. Both keep only the low 16 bits of a write. A tick occurs on every clock where the value is 0, and on that clock the value reloads. In all other clocks the value decrements, so ticks come every reload+1 clocks.
- R3: An enabled channel decrements once per tick. It expires on the tick that finds its counter at 0, so a loaded value N expires on the (N+1)th tick.
- R4: Channel control bit 3 is the interrupt enable. An expiry with bit 3 set sets pending bit 4 and drives that channel's interrupt line high for exactly the following clock. Without bit 3, neither the pending bit nor the line changes.
- R5: Control bit 1 is restart. On expiry with bit 1 set, the counter reloads from the channel reload register and counting continues. Without bit 1, the counter stays at 0 and enable bit 0 clears.
- R6: A control write with bit 4 = 1 clears the pending bit. A control write with bit 4 = 0 leaves it unchanged. Nothing else clears it.
- R7: A control write with bit 2 set copies the channel reload value into the counter. Bit 2 always reads back 0.
- R8: A write to channel word 0 sets the counter directly. A write to channel word 1 changes only the reload register. A counter or control write takes the place of that clock's countdown.
- R9: Window 0 word 2 reads a constant word: bits 2:0 hold the channel count modulo 8, bits 7:3 the base interrupt number, bit 8 = 1 and bit 9 = 1. Writes to it are ignored.
- R10: Word 3 of any window, and any window of a channel that is not present, reads 0.
- R11: Read data appears on the clock after the address is presented. It reflects register state before any write on that same edge.
- R12: Control bits 5 and 6 are stored and read back, but they do not change counting or interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per high clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous clock's address |
| irq | output | NUM_CH | One-clock expiry pulse, one line per channel |

## Verification
The bench runs the prescaler at both a divide-by-one and a divide-by-four setting. If a design decremented to zero instead of past it, or ignored the prescaler reload, its interrupt pulses would land a tick early or on the wrong clock. A one-shot channel is checked after it stops: its enable must have cleared and its counter must read 0. A design that kept running would pulse again. The bench issues pending-flag writes with bit 4 both clear and set; a flag that cleared on any write, or never cleared, shows up on read-back. Load-bit read-back, upper prescaler bits, writes to the capability word, unmapped words and the stored-but-inert bits 5 and 6 are probed as well, since each would otherwise leak wrong values onto `bus_rdata`.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int CTL_EN    = 0;
  localparam int CTL_RST   = 1;
  localparam int CTL_LOAD  = 2;
  localparam int CTL_IE    = 3;
  localparam int CTL_PEND  = 4;
  localparam int CTL_CHAIN = 5;
  localparam int CTL_HALT  = 6;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_RLD  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;
endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] val,
  output logic [PW-1:0] rld,
  output logic          tick
);
  assign tick = (val == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_val)    val <= wdata;
      else if (tick) val <= rld;
      else           val <= val - 1'b1;
    end
  end
endmodule

// File: rtl/mct_channel.sv
module mct_channel
  import mct_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic [31:0]   ctl_rd,
  output logic          en,
  output logic          pend,
  output logic          irq
);
  logic restart, ie, chain, halt;
  logic step, expire;

  assign step   = en && tick && !wr_cnt && !wr_ctl;
  assign expire = step && (cnt == '0);

  assign ctl_rd = {25'd0, halt, chain, pend, ie, 1'b0, restart, en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      rld     <= '0;
      en      <= 1'b0;
      restart <= 1'b0;
      ie      <= 1'b0;
      pend    <= 1'b0;
      chain   <= 1'b0;
      halt    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= expire && ie;
      if (wr_rld) rld <= wdata;
      if (wr_ctl) begin
        en      <= wdata[CTL_EN];
        restart <= wdata[CTL_RST];
        ie      <= wdata[CTL_IE];
        chain   <= wdata[CTL_CHAIN];
        halt    <= wdata[CTL_HALT];
        if (wdata[CTL_PEND]) pend <= 1'b0;
        if (wdata[CTL_LOAD]) cnt  <= rld;
      end else if (expire) begin
        if (ie) pend <= 1'b1;
        if (restart) cnt <= rld;
        else         en  <= 1'b0;
      end else if (step) begin
        cnt <= cnt - 1'b1;
      end
      if (wr_cnt) cnt <= wdata;
    end
  end
endmodule

// File: rtl/mct_unit.sv
module mct_unit
  import mct_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int PW = 16;
  localparam int CW = 32;
  localparam logic [31:0] CFG_WORD =
    {22'd0, 1'b1, 1'b1, IRQ_BASE[4:0], NUM_CH[2:0]};

  logic [3:0]  win;
  word_sel_e   sel;
  logic [PW-1:0] psc_val, psc_rld;
  logic        tick;
  logic [CW-1:0] ch_cnt [NUM_CH];
  logic [CW-1:0] ch_rld [NUM_CH];
  logic [31:0]   ch_ctl [NUM_CH];
  logic [NUM_CH-1:0] ch_en, ch_pend;
  logic [31:0] rd_next;

  assign win = bus_addr[7:4];
  assign sel = word_sel_e'(bus_addr[3:2]);

  mct_prescaler #(.PW(PW)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_val(bus_wr && win == 4'd0 && sel == SEL_CNT),
    .wr_rld(bus_wr && win == 4'd0 && sel == SEL_RLD),
    .wdata (bus_wdata[PW-1:0]),
    .val   (psc_val),
    .rld   (psc_rld),
    .tick  (tick)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (win == 4'(n + 1));
    mct_channel #(.CW(CW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_cnt(hit && sel == SEL_CNT),
      .wr_rld(hit && sel == SEL_RLD),
      .wr_ctl(hit && sel == SEL_CTL),
      .wdata (bus_wdata),
      .cnt   (ch_cnt[n]),
      .rld   (ch_rld[n]),
      .ctl_rd(ch_ctl[n]),
      .en    (ch_en[n]),
      .pend  (ch_pend[n]),
      .irq   (irq[n])
    );
  end

  always_comb begin
    rd_next = '0;
    if (win == 4'd0) begin
      case (sel)
        SEL_CNT: rd_next = {16'd0, psc_val};
        SEL_RLD: rd_next = {16'd0, psc_rld};
        SEL_CTL: rd_next = CFG_WORD;
        default: rd_next = '0;
      endcase
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (win == 4'(n + 1)) begin
          case (sel)
            SEL_CNT: rd_next = ch_cnt[n];
            SEL_RLD: rd_next = ch_rld[n];
            SEL_CTL: rd_next = ch_ctl[n];
            default: rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/mct_checks.sv
module mct_checks #(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_pend
);
  localparam logic [31:0] CFG_EXP =
    32'(NUM_CH % 8) | (32'(IRQ_BASE % 32) << 3) | 32'h300;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    assert_irq_has_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> ch_pend[n]);
    assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_pend[n]) |-> $past(bus_wr && bus_addr[7:4] == 4'(n + 1)
                                  && bus_addr[3:2] == 2'd2 && bus_wdata[4]));
    assert_irq_from_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> $past(ch_en[n]));
  end

  assert_cfg_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[7:2] == 6'd2) |-> bus_rdata == CFG_EXP);
  assert_hole_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[3:2] == 2'd3) |-> bus_rdata == 32'd0);
  assert_psc_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_addr[7:3] == 5'd0) |-> bus_rdata[31:16] == 16'd0);
endmodule

bind mct_unit mct_checks #(.NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE)) u_chk (.*);

// File: tb/sim_mct_unit.sv
module sim_mct_unit;
  localparam int NCH = 2;
  localparam int IB  = 8;
  localparam logic [31:0] CFG = 32'(NCH) | (32'(IB) << 3) | 32'h300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int vecs = 0, errs = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mct_unit #(.NUM_CH(NCH), .IRQ_BASE(IB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference
  int unsigned m_pv, m_pr;
  logic [31:0] m_cnt [NCH];
  logic [31:0] m_rld [NCH];
  bit m_en [NCH], m_rs [NCH], m_ie [NCH], m_pd [NCH], m_cb [NCH], m_hb [NCH];
  bit m_irq [NCH];
  logic [31:0] m_rd;

  function automatic logic [31:0] ctl_word(int c);
    return 32'(m_en[c]) | (32'(m_rs[c]) << 1) | (32'(m_ie[c]) << 3)
         | (32'(m_pd[c]) << 4) | (32'(m_cb[c]) << 5) | (32'(m_hb[c]) << 6);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pv = 0; m_pr = 0; m_rd = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = 0; m_rld[c] = 0; m_irq[c] = 0;
        m_en[c] = 0; m_rs[c] = 0; m_ie[c] = 0; m_pd[c] = 0; m_cb[c] = 0; m_hb[c] = 0;
      end
    end else begin
      int w, s;
      bit tk;
      w = int'(bus_addr[7:4]);
      s = int'(bus_addr[3:2]);
      m_rd = 0;
      if (w == 0) begin
        if (s == 0) m_rd = m_pv;
        else if (s == 1) m_rd = m_pr;
        else if (s == 2) m_rd = CFG;
      end else if (w <= NCH) begin
        if (s == 0) m_rd = m_cnt[w-1];
        else if (s == 1) m_rd = m_rld[w-1];
        else if (s == 2) m_rd = ctl_word(w-1);
      end
      tk = (m_pv == 0);
      if (bus_wr && w == 0 && s == 0) m_pv = bus_wdata & 32'hFFFF;
      else if (tk) m_pv = m_pr;
      else m_pv = m_pv - 1;
      if (bus_wr && w == 0 && s == 1) m_pr = bus_wdata & 32'hFFFF;
      for (int c = 0; c < NCH; c++) begin
        bit cw;
        cw = bus_wr && (w == c + 1);
        m_irq[c] = 0;
        if (cw && s == 2) begin
          m_en[c] = bus_wdata[0]; m_rs[c] = bus_wdata[1]; m_ie[c] = bus_wdata[3];
          m_cb[c] = bus_wdata[5]; m_hb[c] = bus_wdata[6];
          if (bus_wdata[4]) m_pd[c] = 0;
          if (bus_wdata[2]) m_cnt[c] = m_rld[c];
        end else if (cw && s == 0) begin
          m_cnt[c] = bus_wdata;
        end else if (m_en[c] && tk) begin
          if (m_cnt[c] == 0) begin
            if (m_ie[c]) begin m_pd[c] = 1; m_irq[c] = 1; end
            if (m_rs[c]) m_cnt[c] = m_rld[c];
            else m_en[c] = 0;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (cw && s == 1) m_rld[c] = bus_wdata;
      end
    end
  end

  // compare on every falling edge (R11 timing falls out of this)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vecs++;
      if (bus_rdata !== m_rd) begin
        errs++;
        $display("FAIL %s rdata: actual %h expected %h at %0t", cur_req, bus_rdata, m_rd, $time);
      end
      for (int c = 0; c < NCH; c++) begin
        vecs++;
        if (irq[c] !== m_irq[c]) begin
          errs++;
          $display("FAIL %s irq[%0d]: actual %b expected %b at %0t", cur_req, c, irq[c], m_irq[c], $time);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // R11: address at one falling edge, data checked at the next
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    #1;
    vecs++;
    if (bus_rdata !== exp) begin
      errs++;
      $display("FAIL %s read %h: actual %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    cur_req = "R1";
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h10, 0, "R1");
    rd(8'h14, 0, "R1"); rd(8'h18, 0, "R1"); rd(8'h28, 0, "R1");
    cur_req = "R9";
    rd(8'h08, CFG, "R9");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, CFG, "R9");
    cur_req = "R10";
    rd(8'h0C, 0, "R10"); rd(8'h1C, 0, "R10"); rd(8'h30, 0, "R10"); rd(8'hF0, 0, "R10");
    cur_req = "R2";
    wr(8'h04, 32'hABCD_0003);
    rd(8'h04, 32'h0000_0003, "R2");
    cur_req = "R7";
    wr(8'h14, 5);
    wr(8'h18, 32'h0F);
    rd(8'h18, 32'h0B, "R7");
    cur_req = "R3";
    idle(60);
    cur_req = "R5";
    wr(8'h18, 32'h10);
    rd(8'h18, 32'h00, "R6");
    cur_req = "R2";
    wr(8'h04, 0);
    idle(4);
    cur_req = "R4";
    wr(8'h24, 3);
    wr(8'h28, 32'h0D);
    idle(10);
    rd(8'h28, 32'h18, "R5");
    rd(8'h20, 0, "R5");
    cur_req = "R6";
    wr(8'h28, 32'h08);
    rd(8'h28, 32'h18, "R6");
    wr(8'h28, 32'h18);
    rd(8'h28, 32'h08, "R6");
    cur_req = "R8";
    wr(8'h20, 7);
    rd(8'h20, 7, "R8");
    wr(8'h24, 100);
    rd(8'h20, 7, "R8");
    cur_req = "R12";
    wr(8'h28, 32'h69);
    rd(8'h28, 32'h69, "R12");
    idle(12);
    cur_req = "R4";
    wr(8'h28, 32'h13);
    wr(8'h20, 2);
    idle(120);
    rd(8'h28, 32'h03, "R4");
    cur_req = "R8";
    wr(8'h20, 40);
    idle(5);
    finish_run();
  end
endmodule